// File: doc/BRIEF.md
# Serial Converter Digital Front-End Model

This block is a synthesizable stand-in for the digital side of a 16-bit serial sampling converter. It lets a controller under test talk to something that behaves like the real device. The sample value comes from a parallel input port instead of an analog input. A rising edge on the convert strobe starts a conversion, and the conversion length is timed by an internal counter in system-clock cycles. While the counter runs, the busy output is high. When the conversion finishes, the result is loaded into an output shift register, and the controller reads it most significant bit first, one bit per rising edge of the serial clock.

The model also tracks power states: an automatic nap between conversions, an active state during a conversion, and a sleep state. Sleep is armed when two conversions start with no serial-clock rising edge between them. The model enters sleep when the second of those conversions ends, and a later serial-clock rising edge wakes it. The model reports protocol errors on two outputs:
- a strobe edge that lands too late inside a running conversion;
- a strobe that arrives while the model is asleep or before the wake-up time has run out.

Each sampled value is held from the acquisition point of one conversion and converted by the next one. The first conversion after reset therefore returns zero.

Top module: `sadc_if_model`

## Requirements
- R1: After reset, busy_o, sdo_o, cnv_err_o and wake_err_o are 0, and pwr_state_o is 0 (nap).
- R2: A cnv_i rising edge seen in nap starts a conversion. busy_o is high from the next cycle for exactly CONV_CYC cycles, and pwr_state_o reads 1 (active) for that whole time.
- R3: A cnv_i rising edge during a conversion does not restart it. busy_o still falls CONV_CYC cycles after the first start.
- R4: sample_i is latched once per conversion, on the edge where the conversion has run ACQ_CYC cycles. Changes after that edge are not captured. A conversion returns the value latched during the previous conversion, or 0 for the first conversion after reset.
- R5: At the end of a conversion the result is loaded into the shifter and the state returns to nap (0). Before any serial clock, sdo_o shows result bit 15, and each sck_i rising edge then advances sdo_o by one bit toward bit 0.
- R6: After 16 sck_i rising edges since the last load, sdo_o stays 0 until the next load.
- R7: A cnv_i edge of either polarity, seen while the running conversion has already lasted GUARD_CYC or more cycles, gives a one-cycle pulse on cnv_err_o. Edges seen earlier in the conversion give no pulse.
- R8: If two conversions start with no sck_i rising edge between the two starts, the second one ends in sleep (pwr_state_o = 2) with sdo_o held at 0. If there is one sck_i rising edge between them, the state returns to nap.
- R9: In sleep, a cnv_i rising edge starts nothing (busy_o stays 0) and gives a one-cycle wake_err_o pulse. An sck_i rising edge returns the state to nap without shifting, so sdo_o shows bit 15 of the stored result.
- R10: A cnv_i rising edge within WAKE_CYC cycles after waking gives a one-cycle wake_err_o pulse, and the conversion still runs in full. Later strobes give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing counts in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert strobe, sampled in the clk domain |
| sck_i | input | 1 | Serial read clock, sampled in the clk domain |
| sample_i | input | DATA_W | Parallel value standing in for the analog input |
| busy_o | output | 1 | High while a conversion runs |
| sdo_o | output | 1 | Serial result, most significant bit first |
| pwr_state_o | output | 2 | 0 nap, 1 active, 2 sleep |
| cnv_err_o | output | 1 | One-cycle pulse for a strobe edge inside the late window |
| wake_err_o | output | 1 | One-cycle pulse for a strobe in sleep or during wake-up |

## Verification
The bench drives a full sweep of serial words: walking single ones, all-ones, all-zeros and an arithmetic stream. Each word passes through the one-conversion pipeline, which shows whether the held sample, the shift order and the trailing-zero behaviour agree. Strobe re-toggles are placed just inside and just outside the guard boundary, which separates the no-restart rule from the error window. A sample change right after the acquisition point shows whether the latch edge is in the right cycle. A pair of back-to-back conversions without reads, a strobe during sleep, a wake edge and an early strobe after waking together cover each step of the power sequence.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    PWR_NAP    = 2'd0,
    PWR_ACTIVE = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_e;

  // An edge counts as late once the conversion has run guard cycles
  function automatic logic late_edge(input int unsigned elapsed,
                                     input int unsigned guard);
    return elapsed >= guard;
  endfunction

  // Sleep is armed when a prior conversion exists and no read clock followed it
  function automatic logic sleep_arm(input logic had_conv, input logic clocked);
    return had_conv & ~clocked;
  endfunction

endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d_i[g];
    end
    assign prev_o[g] = q;
  end
endmodule

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CONV_CYC  = 300,
  parameter int ACQ_CYC   = 105,
  parameter int GUARD_CYC = 8,
  parameter int WAKE_CYC  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_rise,
  input  logic              cnv_tgl,
  input  logic              sck_rise,
  input  logic [DATA_W-1:0] sample_i,
  output pwr_e              state_o,
  output logic              busy_o,
  output logic              conv_done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              cnv_err_o,
  output logic              wake_err_o
);
  localparam int CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] ACQ_IDX  = CW'(ACQ_CYC - 1);

  pwr_e              st_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] hold_q, res_q;
  logic              conv_seen_q, sck_since_q, armed_q;
  logic [WW-1:0]     wake_q;
  logic              cnv_err_q, wake_err_q;

  // Named internal events
  logic in_conv, asleep, conv_last, start_ok, acq_hit, late_tgl, early_cnv;
  assign in_conv   = (st_q == PWR_ACTIVE);
  assign asleep    = (st_q == PWR_SLEEP);
  assign conv_last = in_conv && (cnt_q == LAST_IDX);
  assign start_ok  = cnv_rise && (st_q == PWR_NAP);
  assign acq_hit   = in_conv && (cnt_q == ACQ_IDX);
  assign late_tgl  = in_conv && cnv_tgl && late_edge(32'(cnt_q), GUARD_CYC);
  assign early_cnv = cnv_rise && (asleep || ((st_q == PWR_NAP) && (wake_q != '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PWR_NAP;
      cnt_q       <= '0;
      hold_q      <= '0;
      res_q       <= '0;
      conv_seen_q <= 1'b0;
      sck_since_q <= 1'b0;
      armed_q     <= 1'b0;
      wake_q      <= '0;
      cnv_err_q   <= 1'b0;
      wake_err_q  <= 1'b0;
    end else begin
      cnv_err_q  <= late_tgl;
      wake_err_q <= early_cnv;
      if (wake_q != '0 && !asleep) wake_q <= wake_q - 1'b1;
      if (sck_rise) sck_since_q <= 1'b1;
      case (st_q)
        PWR_NAP: begin
          if (start_ok) begin
            st_q        <= PWR_ACTIVE;
            cnt_q       <= '0;
            res_q       <= hold_q;
            armed_q     <= sleep_arm(conv_seen_q, sck_since_q);
            conv_seen_q <= 1'b1;
            sck_since_q <= 1'b0;
          end
        end
        PWR_ACTIVE: begin
          if (acq_hit) hold_q <= sample_i;
          if (conv_last) st_q <= armed_q ? PWR_SLEEP : PWR_NAP;
          else           cnt_q <= cnt_q + 1'b1;
        end
        PWR_SLEEP: begin
          if (sck_rise) begin
            st_q    <= PWR_NAP;
            wake_q  <= WW'(WAKE_CYC);
            armed_q <= 1'b0;
          end
        end
        default: st_q <= PWR_NAP;
      endcase
    end
  end

  assign state_o     = st_q;
  assign busy_o      = in_conv;
  assign conv_done_o = conv_last;
  assign result_o    = res_q;
  assign cnv_err_o   = cnv_err_q;
  assign wake_err_o  = wake_err_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy_o && cnt_q == '0));
  // R2
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_last |=> !busy_o);
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && cnv_rise) |=> !(in_conv && cnt_q == '0));
  // R7
  err_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_err_o |-> $past(in_conv));
  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(conv_last && armed_q));
  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !sck_rise) |=> asleep);
  // R10
  wake_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err_o |-> $past(cnv_rise));
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sck_rise_i,
  input  logic              hold_i,
  output logic              sdo_o
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] FULL = BW'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     cnt_q;
  logic              step;

  assign step = sck_rise_i && !hold_i && (cnt_q != FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= FULL;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= '0;
    end else if (step) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sdo_o = !hold_i && (cnt_q != FULL) && sh_q[DATA_W-1];

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_i && cnt_q < BW'(DATA_W - 1)) |=> (sdo_o == $past(sh_q[DATA_W-2])));
  // R6
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_i && cnt_q == BW'(DATA_W - 1)) |=> !sdo_o);
  // R5
  load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (hold_i || sdo_o == $past(data_i[DATA_W-1])));
endmodule

// File: rtl/sadc_if_model.sv
module sadc_if_model
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CONV_CYC  = 300,
  parameter int ACQ_CYC   = 105,
  parameter int GUARD_CYC = 8,
  parameter int WAKE_CYC  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              sdo_o,
  output logic [1:0]        pwr_state_o,
  output logic              cnv_err_o,
  output logic              wake_err_o
);
  logic [1:0]        prev;
  logic              cnv_rise, cnv_tgl, sck_rise, conv_done;
  logic [DATA_W-1:0] result;
  pwr_e              state;

  sadc_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .d_i({sck_i, cnv_i}), .prev_o(prev)
  );

  assign cnv_rise = cnv_i & ~prev[0];
  assign cnv_tgl  = cnv_i ^ prev[0];
  assign sck_rise = sck_i & ~prev[1];

  sadc_conv_ctrl #(
    .DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC),
    .GUARD_CYC(GUARD_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cnv_rise(cnv_rise), .cnv_tgl(cnv_tgl),
    .sck_rise(sck_rise), .sample_i(sample_i), .state_o(state),
    .busy_o(busy_o), .conv_done_o(conv_done), .result_o(result),
    .cnv_err_o(cnv_err_o), .wake_err_o(wake_err_o)
  );

  sadc_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(conv_done), .data_i(result),
    .sck_rise_i(sck_rise), .hold_i(state == PWR_SLEEP), .sdo_o(sdo_o)
  );

  assign pwr_state_o = state;
endmodule

// File: tb/tb_sadc_if_model.sv
`timescale 1ns/1ps
module tb_sadc_if_model;
  localparam int C = 12, A = 5, G = 3, W = 6;

  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0, sck = 1'b0;
  logic [15:0] sample = '0;
  logic busy, sdo, cerr, werr;
  logic [1:0] pwr;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] hold_m = '0;
  logic [15:0] last_res;

  always #2.5 clk = ~clk;

  sadc_if_model #(.DATA_W(16), .CONV_CYC(C), .ACQ_CYC(A), .GUARD_CYC(G), .WAKE_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sample_i(sample),
    .busy_o(busy), .sdo_o(sdo), .pwr_state_o(pwr), .cnv_err_o(cerr), .wake_err_o(werr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start at a negedge; flips cnv at negedge k when bit k of mask is set; optional sample change
  task automatic conv_custom(input logic [15:0] nv, input int mask, input int chg_k,
                             input logic [15:0] chg_v, output int len, output int errs,
                             output int wakes);
    int k;
    last_res = hold_m;
    len = 0; errs = 0; wakes = 0;
    sample = nv;
    cnv = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (busy) len++;
      if (cerr) errs++;
      if (werr) wakes++;
      if (k < 32 && mask[k]) cnv = ~cnv;
      if (k == chg_k) sample = chg_v;
    end while ((busy || k < 2) && k < 80);
    cnv = 1'b0;
    hold_m = nv;
  endtask

  task automatic do_conv(input logic [15:0] nv, input string req);
    int len, errs, wakes;
    conv_custom(nv, 2, 0, '0, len, errs, wakes);
    chk({req, " busy length"}, len, C);
    chk({req, " no cnv_err"}, errs, 0);
  endtask

  task automatic read_word(input logic [15:0] exp, input string req);
    logic [15:0] got;
    for (int i = 0; i < 16; i++) begin
      got[15-i] = sdo;
      sck = 1'b1;
      @(negedge clk);
      sck = 1'b0;
      @(negedge clk);
    end
    chk({req, " serial word"}, got, exp);
    chk("R6 sdo low after 16 bits", sdo, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int len, errs, wakes;
    logic [15:0] r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 pwr", pwr, 0);
    chk("R1 cnv_err", cerr, 0);
    chk("R1 wake_err", werr, 0);

    // R2, R4: first result after reset is zero; check active state during conversion
    sample = 16'h1234;
    cnv = 1'b1;
    @(negedge clk);
    cnv = 1'b0;
    chk("R2 busy up", busy, 1);
    chk("R2 pwr active", pwr, 1);
    len = 1;
    while (busy && len < 80) begin
      @(negedge clk);
      if (busy) len++;
    end
    chk("R2 busy length", len, C);
    last_res = hold_m;
    hold_m = 16'h1234;
    chk("R5 back to nap", pwr, 0);
    read_word(16'h0000, "R4 first result zero");

    // R4: change after acquisition edge is not captured
    conv_custom(16'hBEEF, 2, A + 2, 16'h0BAD, len, errs, wakes);
    chk("R2 busy length", len, C);
    read_word(last_res, "R4 pipelined value");

    // R5 sweep: walking ones, extremes and an arithmetic stream
    for (int i = 0; i < 24; i++) begin
      logic [15:0] v;
      if (i < 16)       v = 16'(1 << i);
      else if (i == 16) v = 16'hFFFF;
      else if (i == 17) v = 16'h0000;
      else              v = 16'(i * 16'h9E37 + 16'h0101);
      do_conv(v, "R2");
      chk("R8 nap after read-separated conversion", pwr, 0);
      read_word(last_res, "R5 sweep");
    end
    do_conv(16'h7F01, "R2");
    read_word(last_res, "R5 sweep tail");

    // R3 + R7: re-toggles inside guard do not restart and raise no error
    conv_custom(16'h2222, (1 << 1) | (1 << 2) | (1 << 3), 0, '0, len, errs, wakes);
    chk("R3 busy length after re-strobe", len, C);
    chk("R7 early toggles no error", errs, 0);
    read_word(last_res, "R3 result");

    // R7 boundary: fall at k=G is seen with G-1 cycles elapsed (legal)
    conv_custom(16'h3333, 1 << G, 0, '0, len, errs, wakes);
    chk("R7 edge just inside guard", errs, 0);
    read_word(last_res, "R7 result");
    // R7: fall at k=G+1 is seen with G cycles elapsed (late)
    conv_custom(16'h4444, 1 << (G + 1), 0, '0, len, errs, wakes);
    chk("R7 late edge single pulse", errs, 1);
    chk("R3 length unchanged by late edge", len, C);
    read_word(last_res, "R7 result");

    // R8: two conversions without a read clock between starts
    do_conv(16'h5A5A, "R2");
    chk("R8 first of pair ends in nap", pwr, 0);
    do_conv(16'hC3C3, "R2");
    r2 = last_res;
    chk("R8 sleep entered", pwr, 2);
    chk("R8 sdo low in sleep", sdo, 0);

    // R9: strobe in sleep is ignored and flagged
    cnv = 1'b1;
    @(negedge clk);
    cnv = 1'b0;
    chk("R9 wake_err on strobe in sleep", werr, 1);
    chk("R9 busy stays low", busy, 0);
    chk("R9 still asleep", pwr, 2);
    @(negedge clk);
    chk("R9 wake_err one cycle", werr, 0);
    // R9: wake on read clock, no shift
    sck = 1'b1;
    @(negedge clk);
    sck = 1'b0;
    chk("R9 woke to nap", pwr, 0);
    chk("R9 wake edge does not shift", sdo, r2[15]);

    // R10: early strobe after wake still converts but is flagged
    conv_custom(16'h0F0F, 2, 0, '0, len, errs, wakes);
    chk("R10 early strobe flagged", wakes, 1);
    chk("R10 conversion runs full length", len, C);
    chk("R10 nap after", pwr, 0);
    read_word(last_res, "R10 result");
    repeat (W + 2) @(negedge clk);
    conv_custom(16'hF0F0, 2, 0, '0, len, errs, wakes);
    chk("R10 no flag after wake time", wakes, 0);
    read_word(last_res, "R10 later result");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule